// File: doc/BRIEF.md
# Port-Size-Aware Byte Lane Enable Generator

This block produces the four byte-lane strobes that a general-purpose chip-select machine drives onto a 32-bit external data bus. For each access it takes the transfer size, the two low address bits, the direction and the port-size code of the selected bank. From these it works out which byte lanes carry valid data. A per-bank mode bit decides how the strobes behave:

- In write-strobe mode they assert only on write cycles.
- In byte-select mode they assert on reads and writes alike.

The lanes chosen, and the strobe timing, are the same in both modes.

Lane 0 covers the most significant byte of the bus (D0–D7) and lane 3 the least significant (D24–D31). A 16-bit device sits on lanes 0 and 1, and an 8-bit device sits on lane 0. The strobes are active low and registered. They are held deasserted unless the bank is selected and the strobe phase input from the surrounding timing logic is active. An offset or size that is not legal, or a reserved port-size code, asserts no strobe and raises an error flag instead.

Top module: `lane_strobe_gen`

## Requirements
- R1: While reset is held and after its release, before any access, `strb_n_o` is 4'b1111 and `err_o` is 0.
- R2: With `be_mode_i`=0 (write-strobe mode), a read (`wr_i`=0) asserts no strobe. A write asserts the decoded lanes.
- R3: With `be_mode_i`=1 (byte-select mode), a read asserts exactly the same lanes as the equal write.
- R4: `strb_n_o[i]` is the active-low strobe for lane i, where lane 0 is D0–D7. On a 32-bit port (`psize_i`=2'b00), a byte transfer (`tsize_i`=2'b01) at offset n (`addr_lo_i`=n) asserts lane n only.
- R5: On a 32-bit port, a half-word (`tsize_i`=2'b10) asserts lanes 0 and 1 at offset 2'b00 and lanes 2 and 3 at offset 2'b10. A word (`tsize_i`=2'b00) at offset 2'b00 asserts all four lanes.
- R6: On a 16-bit port (`psize_i`=2'b10), a byte asserts lane 0 when `addr_lo_i[0]`=0 and lane 1 when it is 1. An aligned half-word or word asserts lanes 0 and 1. Lanes 2 and 3 never assert.
- R7: On an 8-bit port (`psize_i`=2'b01), every legal transfer asserts lane 0 only.
- R8: Each of the following is illegal: a half-word with `addr_lo_i[0]`=1, a word at a nonzero offset, `tsize_i`=2'b11, or `psize_i`=2'b11. An illegal access, selected and in phase, asserts no strobe and sets `err_o` in either direction.
- R9: When `phase_i`=0 or `sel_i`=0, all strobes are deasserted and `err_o` is 0.
- R10: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Bank is selected for this access |
| phase_i | input | 1 | Strobe phase from the chip-select timing logic |
| wr_i | input | 1 | 1 = write, 0 = read |
| be_mode_i | input | 1 | 1 = byte-select mode, 0 = write-strobe mode |
| tsize_i | input | 2 | Transfer size: 01 byte, 10 half-word, 00 word, 11 reserved |
| addr_lo_i | input | 2 | Two low address bits (byte offset) |
| psize_i | input | 2 | Port size: 00 32-bit, 10 16-bit, 01 8-bit, 11 reserved |
| strb_n_o | output | 4 | Active-low lane strobes, bit i = lane i |
| err_o | output | 1 | Illegal size, offset or port-size combination |

## Verification
The assertions take it that every control input is a known value at each rising edge. They also take it that the port-size code and mode bit reach the block together with the access they belong to, so a property may relate one cycle's inputs to the strobes one edge later. The bench keeps to this by changing every input only on the falling clock edge, in one step. It then samples outputs on the following falling edge, after exactly one register stage. Reserved codes are driven on purpose only in the illegal-access scenario. There they are expected to produce the error flag rather than undefined lanes.

// File: rtl/lse_pkg.sv
package lse_pkg;
  localparam int NLANES = 4;
  localparam int OFFW   = $clog2(NLANES);

  typedef logic [NLANES-1:0] lane_mask_t;

  typedef enum logic [1:0] {
    PS_32  = 2'b00,
    PS_8   = 2'b01,
    PS_16  = 2'b10,
    PS_RSV = 2'b11
  } port_size_e;

  typedef enum logic [1:0] {
    TS_WORD = 2'b00,
    TS_BYTE = 2'b01,
    TS_HALF = 2'b10,
    TS_RSV  = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/lse_rst_sync.sv
module lse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lse_lane_decode.sv
module lse_lane_decode
  import lse_pkg::*;
(
  input  port_size_e       psize,
  input  xfer_size_e       tsize,
  input  logic [OFFW-1:0]  offset,
  output lane_mask_t       mask,
  output logic             illegal
);
  lane_mask_t byte_hot;
  logic       size_ok;

  // One lane per byte offset on a full-width port
  for (genvar g = 0; g < NLANES; g++) begin : g_hot
    assign byte_hot[g] = (offset == OFFW'(g));
  end

  always_comb begin
    unique case (tsize)
      TS_BYTE: size_ok = 1'b1;
      TS_HALF: size_ok = ~offset[0];
      TS_WORD: size_ok = (offset == '0);
      default: size_ok = 1'b0;
    endcase
  end

  always_comb begin
    mask    = '0;
    illegal = ~size_ok;
    unique case (psize)
      PS_32: begin
        unique case (tsize)
          TS_BYTE: mask = byte_hot;
          TS_HALF: mask = offset[1] ? lane_mask_t'(4'b1100) : lane_mask_t'(4'b0011);
          TS_WORD: mask = '1;
          default: mask = '0;
        endcase
      end
      PS_16: begin
        if (tsize == TS_BYTE) mask = offset[0] ? lane_mask_t'(4'b0010) : lane_mask_t'(4'b0001);
        else                  mask = lane_mask_t'(4'b0011);
      end
      PS_8:    mask = lane_mask_t'(4'b0001);
      default: illegal = 1'b1;
    endcase
    if (illegal) mask = '0;
  end
endmodule

// File: rtl/lse_lane_qualify.sv
module lse_lane_qualify
  import lse_pkg::*;
(
  input  lane_mask_t mask,
  input  logic       illegal,
  input  logic       sel,
  input  logic       phase,
  input  logic       wr,
  input  logic       be_mode,
  output lane_mask_t strb_n_d,
  output logic       err_d
);
  logic active;
  logic dir_ok;
  logic fire;

  always_comb begin
    active   = sel & phase;
    dir_ok   = be_mode | wr;
    fire     = active & dir_ok & ~illegal;
    strb_n_d = ~(mask & {NLANES{fire}});
    err_d    = active & illegal;
  end
endmodule

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen
  import lse_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  logic       phase_i,
  input  logic       wr_i,
  input  logic       be_mode_i,
  input  logic [1:0] tsize_i,
  input  logic [1:0] addr_lo_i,
  input  logic [1:0] psize_i,
  output logic [3:0] strb_n_o,
  output logic       err_o
);
  logic       rst_n_s;
  lane_mask_t mask;
  logic       illegal;
  lane_mask_t strb_n_d;
  logic       err_d;
  lane_mask_t strb_n_q;
  logic       err_q;
  logic       upd_en;

  lse_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lse_lane_decode u_dec (
    .psize   (port_size_e'(psize_i)),
    .tsize   (xfer_size_e'(tsize_i)),
    .offset  (addr_lo_i),
    .mask    (mask),
    .illegal (illegal)
  );

  lse_lane_qualify u_qual (
    .mask     (mask),
    .illegal  (illegal),
    .sel      (sel_i),
    .phase    (phase_i),
    .wr       (wr_i),
    .be_mode  (be_mode_i),
    .strb_n_d (strb_n_d),
    .err_d    (err_d)
  );

  // Load only when something changes
  always_comb begin
    upd_en = (strb_n_d != strb_n_q) | (err_d != err_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      strb_n_q <= '1;
      err_q    <= 1'b0;
    end else if (upd_en) begin
      strb_n_q <= strb_n_d;
      err_q    <= err_d;
    end
  end

  assign strb_n_o = strb_n_q;
  assign err_o    = err_q;

  // R9: no selection or no phase leaves every lane idle next cycle
  a_r9_idle_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(sel_i && phase_i) |=> (&strb_n_o && !err_o));

  // R2: write-strobe mode never fires on a read
  a_r2_no_read_strobe: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!be_mode_i && !wr_i) |=> &strb_n_o);

  // R8: an error cycle carries no strobe
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |-> &strb_n_o);

  // R6: narrow 16-bit port keeps the upper lanes idle
  a_r6_upper_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    (psize_i == 2'b10) |=> &strb_n_o[3:2]);

  // R7: 8-bit port uses lane 0 only
  a_r7_lane0_only: assert property (@(posedge clk) disable iff (!rst_n_s)
    (psize_i == 2'b01) |=> &strb_n_o[3:1]);

  // R4: a byte never strobes more than one lane
  a_r4_byte_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tsize_i == 2'b01) |=> $countones(~strb_n_o) <= 1);

  // R10: outputs only move after an input change
  a_r10_registered: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($stable({sel_i, phase_i, wr_i, be_mode_i, tsize_i, addr_lo_i, psize_i}) &&
     $stable(strb_n_o)) |=> $stable(strb_n_o));
endmodule

// File: tb/sim_lane_strobe_gen.sv
`timescale 1ns/1ps
module sim_lane_strobe_gen;
  logic       clk;
  logic       rst_n;
  logic       sel_i, phase_i, wr_i, be_mode_i;
  logic [1:0] tsize_i, addr_lo_i, psize_i;
  logic [3:0] strb_n_o;
  logic       err_o;

  int n_chk;
  int n_bad;

  lane_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .phase_i(phase_i), .wr_i(wr_i),
    .be_mode_i(be_mode_i), .tsize_i(tsize_i), .addr_lo_i(addr_lo_i),
    .psize_i(psize_i), .strb_n_o(strb_n_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [3:0] exp_s, input logic exp_e);
    n_chk++;
    if (strb_n_o !== exp_s || err_o !== exp_e) begin
      n_bad++;
      $display("FAIL %s: strb_n=%b err=%b expected strb_n=%b err=%b",
               req, strb_n_o, err_o, exp_s, exp_e);
    end
  endtask

  // Drive on a falling edge, sample one full cycle later (after one register)
  task automatic access(input logic sel, input logic ph, input logic wr, input logic bem,
                        input logic [1:0] ts, input logic [1:0] off, input logic [1:0] ps);
    @(negedge clk);
    sel_i = sel; phase_i = ph; wr_i = wr; be_mode_i = bem;
    tsize_i = ts; addr_lo_i = off; psize_i = ps;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    sel_i = 1'b1; phase_i = 1'b1; wr_i = 1'b1; be_mode_i = 1'b1;
    tsize_i = 2'b00; addr_lo_i = 2'b00; psize_i = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b1111, 1'b0);
    sel_i = 1'b0; phase_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 4'b1111, 1'b0);
  endtask

  task automatic t_port32_bytes;
    for (int a = 0; a < 4; a++) begin
      access(1, 1, 1, 0, 2'b01, a[1:0], 2'b00);
      check("R4 32-bit byte", ~(4'b0001 << a), 1'b0);
    end
  endtask

  task automatic t_port32_wide;
    access(1, 1, 1, 0, 2'b10, 2'b00, 2'b00);
    check("R5 half at 00", 4'b1100, 1'b0);
    access(1, 1, 1, 0, 2'b10, 2'b10, 2'b00);
    check("R5 half at 10", 4'b0011, 1'b0);
    access(1, 1, 1, 0, 2'b00, 2'b00, 2'b00);
    check("R5 word", 4'b0000, 1'b0);
  endtask

  task automatic t_port16;
    access(1, 1, 1, 0, 2'b01, 2'b00, 2'b10);
    check("R6 byte A31=0", 4'b1110, 1'b0);
    access(1, 1, 1, 0, 2'b01, 2'b11, 2'b10);
    check("R6 byte A31=1", 4'b1101, 1'b0);
    access(1, 1, 1, 0, 2'b01, 2'b10, 2'b10);
    check("R6 byte off 10", 4'b1110, 1'b0);
    access(1, 1, 1, 0, 2'b10, 2'b10, 2'b10);
    check("R6 half", 4'b1100, 1'b0);
    access(1, 1, 1, 0, 2'b00, 2'b00, 2'b10);
    check("R6 word", 4'b1100, 1'b0);
  endtask

  task automatic t_port8;
    access(1, 1, 1, 0, 2'b01, 2'b11, 2'b01);
    check("R7 byte", 4'b1110, 1'b0);
    access(1, 1, 1, 0, 2'b10, 2'b10, 2'b01);
    check("R7 half", 4'b1110, 1'b0);
    access(1, 1, 1, 0, 2'b00, 2'b00, 2'b01);
    check("R7 word", 4'b1110, 1'b0);
  endtask

  task automatic t_we_mode;
    access(1, 1, 0, 0, 2'b00, 2'b00, 2'b00);
    check("R2 read word", 4'b1111, 1'b0);
    access(1, 1, 0, 0, 2'b01, 2'b01, 2'b00);
    check("R2 read byte", 4'b1111, 1'b0);
    access(1, 1, 1, 0, 2'b01, 2'b01, 2'b00);
    check("R2 write byte", 4'b1101, 1'b0);
  endtask

  task automatic t_be_mode;
    access(1, 1, 0, 1, 2'b01, 2'b10, 2'b00);
    check("R3 read byte", 4'b1011, 1'b0);
    access(1, 1, 1, 1, 2'b01, 2'b10, 2'b00);
    check("R3 write byte", 4'b1011, 1'b0);
    access(1, 1, 0, 1, 2'b10, 2'b00, 2'b10);
    check("R3 read half 16", 4'b1100, 1'b0);
  endtask

  task automatic t_illegal;
    access(1, 1, 1, 0, 2'b10, 2'b01, 2'b00);
    check("R8 misaligned half", 4'b1111, 1'b1);
    access(1, 1, 1, 0, 2'b00, 2'b10, 2'b00);
    check("R8 misaligned word", 4'b1111, 1'b1);
    access(1, 1, 1, 0, 2'b11, 2'b00, 2'b00);
    check("R8 reserved size", 4'b1111, 1'b1);
    access(1, 1, 0, 0, 2'b01, 2'b00, 2'b11);
    check("R8 reserved port", 4'b1111, 1'b1);
    access(1, 1, 1, 0, 2'b00, 2'b11, 2'b10);
    check("R8 16-bit misaligned word", 4'b1111, 1'b1);
    access(1, 1, 1, 0, 2'b00, 2'b00, 2'b00);
    check("R8 recovery", 4'b0000, 1'b0);
  endtask

  task automatic t_gating;
    access(1, 0, 1, 1, 2'b00, 2'b00, 2'b00);
    check("R9 phase low", 4'b1111, 1'b0);
    access(0, 1, 1, 1, 2'b00, 2'b00, 2'b00);
    check("R9 not selected", 4'b1111, 1'b0);
    access(0, 1, 1, 1, 2'b11, 2'b00, 2'b11);
    check("R9 illegal unselected", 4'b1111, 1'b0);
  endtask

  task automatic t_latency;
    access(0, 0, 1, 0, 2'b00, 2'b00, 2'b00);
    @(negedge clk);
    sel_i = 1'b1; phase_i = 1'b1;
    #2;
    check("R10 before edge", 4'b1111, 1'b0);
    @(posedge clk);
    #2;
    check("R10 after edge", 4'b0000, 1'b0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_port32_bytes();
    t_port32_wide();
    t_port16();
    t_port8();
    t_we_mode();
    t_be_mode();
    t_illegal();
    t_gating();
    t_latency();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule